// File: doc/BRIEF.md
# Streaming Hash Message Padder

This block sits in front of a hash compression core. It takes one message at a time as a byte stream with a valid/ready handshake and an end-of-message flag. It then hands the core complete message blocks on a wide bus. The block size is chosen per message: 64-byte blocks carry an 8-byte length trailer, and 128-byte blocks carry a 16-byte one. Input bytes collect in a block buffer. A block goes out only when it is full. At the end of the message the block adds the marker byte, the zero fill and the big-endian bit length. This produces one final block, or two when the tail leaves no room for the trailer.

The byte count is 128 bits wide and is kept as two 64-bit words with a carry between them. A terminating beat may carry no byte, which is how an empty message is sent. Input is stalled while a block waits on the output. After the final block of a message is taken, the block is ready for the next message.

Top module: `sha_block_padder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Byte k of a block (k = 0 is the first in stream order) appears on `out_block[1023-8k -: 8]`. In 64-byte mode `out_block[511:0]` is always zero.
- R3: A data block is emitted only when it holds a full 64 or 128 bytes. A block filled by the edge that accepts its last byte is valid on the next cycle, with `out_last` = 0.
- R4: The byte 0x80 follows the last message byte directly, and every byte between it and the length trailer is zero.
- R5: The final block ends with the message length in bits, big-endian, in 8 bytes (64-byte mode) or 16 bytes (128-byte mode; high 64 bits first). `out_last` is 1 only on that block.
- R6: When the message length mod block size is at least 56 (64-byte mode) or 112 (128-byte mode), an extra block holding only zero fill and the trailer follows the marker block.
- R7: A beat with `in_keep` = 0 adds no byte. A message made only of such a beat with `in_last` = 1 gives exactly one block: 0x80, zeros, and a zero length.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_block` and `out_last` hold. `in_ready` is never 1 while `out_valid` is 1.
- R9: `mode_wide` (1 = 128-byte blocks) is taken on the first beat of a message. Changes later in the same message have no effect.
- R10: Once the final block is accepted, the buffer and the byte count return to empty, so the next message is padded from a zero length.
- R11: When the marker fits in the current block, the final block is valid two cycles after the edge that accepts the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wide | input | 1 | Block size select, taken on a message's first beat: 0 = 64 bytes, 1 = 128 bytes |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 8 | Message byte |
| in_keep | input | 1 | Beat carries a byte |
| in_last | input | 1 | Beat ends the message |
| out_valid | output | 1 | Block on `out_block` is valid |
| out_ready | input | 1 | Downstream takes the block |
| out_block | output | 1024 | Block, first byte in the top bits |
| out_last | output | 1 | Block is the final one of its message |

## Verification
A full data block is due one cycle after the edge that accepts its last byte. A final block that needs no spill is due two cycles after the last beat, because the marker write takes one cycle. A spill block is followed by its trailer-only block as soon as the spill is accepted. The bench samples on the falling edge, so each of these counts lands between two rising edges. Directed steps check `out_valid` exactly one and two falling edges after the accepting edge. The monitor compares every accepted block against a queue built from the padding arithmetic in the bench, and checks the hold and stall rules on every cycle under a stalling `out_ready`.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;

  localparam int NARROW_BYTES = 64;
  localparam int WIDE_BYTES   = 128;
  localparam int NARROW_TRL   = 8;
  localparam int WIDE_TRL     = 16;
  localparam int LEN_BITS     = 128;

  typedef enum logic [1:0] {ST_FILL, ST_MARK, ST_EMIT} pad_state_e;
  typedef enum logic [1:0] {EK_DATA, EK_SPILL, EK_FINAL} emit_kind_e;

  function automatic int blk_bytes(input logic wide);
    return wide ? WIDE_BYTES : NARROW_BYTES;
  endfunction

  function automatic int trl_bytes(input logic wide);
    return wide ? WIDE_TRL : NARROW_TRL;
  endfunction

  // first byte position of the length trailer
  function automatic int trl_pos(input logic wide);
    return blk_bytes(wide) - trl_bytes(wide);
  endfunction

  // byte of the big-endian trailer at block position pos
  function automatic logic [7:0] trl_byte(input logic [LEN_BITS-1:0] bits,
                                          input logic wide, input int pos);
    int j;
    int sh;
    j  = pos - trl_pos(wide);
    sh = 8 * (trl_bytes(wide) - 1 - j);
    return 8'(bits >> sh);
  endfunction

endpackage

// File: rtl/sha_pad_counter.sv
module sha_pad_counter #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              clr,
  output logic [2*WORD_W-1:0] count,
  output logic              carry_evt,
  output logic              count_zero
);
  logic [WORD_W-1:0] lo_q, hi_q;

  assign carry_evt  = inc && (&lo_q);
  assign count      = {hi_q, lo_q};
  assign count_zero = (lo_q == '0) && (hi_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clr) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (inc) begin
      lo_q <= lo_q + 1'b1;
      if (carry_evt) hi_q <= hi_q + 1'b1;
    end
  end
endmodule

// File: rtl/sha_pad_buffer.sv
module sha_pad_buffer #(
  parameter int NBYTES = 128,
  parameter int PTR_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PTR_W-1:0]    wr_ptr,
  input  logic [7:0]          wr_byte,
  output logic [NBYTES*8-1:0] buf_flat
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cell_q <= '0;
      else if (wr_en && (wr_ptr == PTR_W'(i)))      cell_q <= wr_byte;
    end
    assign buf_flat[i*8 +: 8] = cell_q;
  end
endmodule

// File: rtl/sha_pad_assemble.sv
module sha_pad_assemble
  import sha_pad_pkg::*;
#(
  parameter int NBYTES = 128,
  parameter int PTR_W  = 8
) (
  input  logic [NBYTES*8-1:0]  buf_flat,
  input  logic [PTR_W-1:0]     fill_ptr,
  input  logic                 final_blk,
  input  logic                 wide,
  input  logic [LEN_BITS-1:0]  len_bits,
  output logic [NBYTES*8-1:0]  blk
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [7:0] lane;
    logic       in_trl;
    always_comb begin
      in_trl = (i >= trl_pos(wide)) && (i < blk_bytes(wide));
      if (PTR_W'(i) < fill_ptr)        lane = buf_flat[i*8 +: 8];
      else if (final_blk && in_trl)    lane = trl_byte(len_bits, wide, i);
      else                             lane = 8'h00;
    end
    assign blk[NBYTES*8-1-8*i -: 8] = lane;
  end
endmodule

// File: rtl/sha_pad_ctrl.sv
module sha_pad_ctrl
  import sha_pad_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wide,
  input  logic             in_valid,
  input  logic             in_keep,
  input  logic             in_last,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [7:0]       wr_byte,
  output logic             cnt_inc,
  output logic             cnt_clr,
  output logic [PTR_W-1:0] fill_ptr,
  output logic             wide_q,
  output logic             final_blk,
  output logic             mark_evt,
  output logic             full_evt
);
  pad_state_e       state_q;
  emit_kind_e       kind_q;
  logic [PTR_W-1:0] ptr_q;
  logic             fresh_q;
  logic             tail_q;
  logic             wide_use;
  logic             take;
  logic             byte_take;
  logic             out_take;
  logic [PTR_W-1:0] ptr_inc;

  always_comb begin
    in_ready  = (state_q == ST_FILL);
    out_valid = (state_q == ST_EMIT);
    final_blk = (kind_q == EK_FINAL);
    out_last  = out_valid && final_blk;
    wide_use  = fresh_q ? mode_wide : wide_q;
    take      = in_ready && in_valid;
    byte_take = take && in_keep;
    out_take  = out_valid && out_ready;
    ptr_inc   = ptr_q + 1'b1;
    full_evt  = byte_take && (ptr_inc == PTR_W'(blk_bytes(wide_use)));
    mark_evt  = (state_q == ST_MARK);
    wr_en     = byte_take || mark_evt;
    wr_ptr    = ptr_q;
    wr_byte   = mark_evt ? 8'h80 : in_data;
    cnt_inc   = byte_take;
    cnt_clr   = out_take && final_blk;
    fill_ptr  = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      kind_q  <= EK_DATA;
      ptr_q   <= '0;
      fresh_q <= 1'b1;
      tail_q  <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FILL: if (take) begin
          if (fresh_q) begin
            wide_q  <= mode_wide;
            fresh_q <= 1'b0;
          end
          if (byte_take) ptr_q <= ptr_inc;
          if (full_evt) begin
            state_q <= ST_EMIT;
            kind_q  <= EK_DATA;
            tail_q  <= in_last;
          end else if (in_last) begin
            state_q <= ST_MARK;
          end
        end
        ST_MARK: begin
          ptr_q   <= ptr_inc;
          kind_q  <= (ptr_q < PTR_W'(trl_pos(wide_q))) ? EK_FINAL : EK_SPILL;
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (out_take) begin
          ptr_q <= '0;
          unique case (kind_q)
            EK_DATA: begin
              state_q <= tail_q ? ST_MARK : ST_FILL;
              tail_q  <= 1'b0;
            end
            EK_SPILL: kind_q <= EK_FINAL;
            default: begin
              state_q <= ST_FILL;
              kind_q  <= EK_DATA;
              fresh_q <= 1'b1;
            end
          endcase
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/sha_block_padder.sv
module sha_block_padder
  import sha_pad_pkg::*;
#(
  parameter int MAX_BYTES = WIDE_BYTES,
  parameter int CNT_WORD  = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_wide,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  input  logic                   in_keep,
  input  logic                   in_last,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [MAX_BYTES*8-1:0] out_block,
  output logic                   out_last
);
  localparam int PTR_W = $clog2(MAX_BYTES + 1);
  localparam int CNT_W = 2 * CNT_WORD;

  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  logic [7:0]       wr_byte;
  logic             cnt_inc, cnt_clr;
  logic [PTR_W-1:0] fill_ptr;
  logic             wide_q;
  logic             final_blk;
  logic             mark_evt;
  logic             full_evt;
  logic             carry_evt;
  logic             count_zero;
  logic [CNT_W-1:0] count;
  logic [LEN_BITS-1:0] len_bits;
  logic [MAX_BYTES*8-1:0] buf_flat;

  assign len_bits = LEN_BITS'(count) << 3;

  sha_pad_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk, .rst_n, .mode_wide, .in_valid, .in_keep, .in_last, .in_data,
    .in_ready, .out_ready, .out_valid, .out_last,
    .wr_en, .wr_ptr, .wr_byte, .cnt_inc, .cnt_clr, .fill_ptr,
    .wide_q, .final_blk, .mark_evt, .full_evt
  );

  sha_pad_counter #(.WORD_W(CNT_WORD)) u_cnt (
    .clk, .rst_n, .inc(cnt_inc), .clr(cnt_clr), .count,
    .carry_evt, .count_zero
  );

  sha_pad_buffer #(.NBYTES(MAX_BYTES), .PTR_W(PTR_W)) u_buf (
    .clk, .rst_n, .wr_en, .wr_ptr, .wr_byte, .buf_flat
  );

  sha_pad_assemble #(.NBYTES(MAX_BYTES), .PTR_W(PTR_W)) u_asm (
    .buf_flat, .fill_ptr, .final_blk, .wide(wide_q), .len_bits,
    .blk(out_block)
  );
endmodule

// File: rtl/sha_pad_checker.sv
module sha_pad_checker #(
  parameter int NBYTES = 128,
  parameter int PTR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [NBYTES*8-1:0] out_block,
  input logic [PTR_W-1:0]  fill_ptr,
  input logic              mark_evt,
  input logic              full_evt,
  input logic              count_zero
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_block) && $stable(out_last));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && fill_ptr == '0 && count_zero);

  assert_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_evt |=> out_valid);

  assert_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> out_valid && !out_last);

  assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ptr <= PTR_W'(NBYTES));
endmodule

bind sha_block_padder sha_pad_checker #(.NBYTES(MAX_BYTES), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_block(out_block),
  .fill_ptr(fill_ptr), .mark_evt(mark_evt), .full_evt(full_evt),
  .count_zero(count_zero)
);

// File: tb/sha_block_padder_tb_top.sv
`timescale 1ns/1ps
module sha_block_padder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wide = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic in_keep = 1'b0;
  logic in_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [1023:0] out_block;
  logic out_last;

  always #2.5 clk = ~clk;

  sha_block_padder dut_i (
    .clk, .rst_n, .mode_wide, .in_valid, .in_ready, .in_data, .in_keep,
    .in_last, .out_valid, .out_ready, .out_block, .out_last
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int bp_mode = 0;
  bit done = 0;

  logic [1023:0] exp_blk_q[$];
  bit            exp_last_q[$];
  string         exp_tag_q[$];

  task automatic chk(input bit ok, input string req, input logic [1023:0] act,
                     input logic [1023:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      finish_up();
    end
  end

  // padding worked out from the requirements
  function automatic void build(input logic [7:0] m[$], input bit wide, input string tag);
    logic [7:0] p[$];
    logic [127:0] bits;
    int bsz, tsz, l, lm, pad, nblk;
    bsz = wide ? 128 : 64;
    tsz = wide ? 16 : 8;
    l = m.size();
    lm = l % bsz;
    pad = (lm < bsz - tsz) ? (bsz - tsz - lm) : (2 * bsz - tsz - lm);
    p = m;
    p.push_back(8'h80);
    for (int k = 1; k < pad; k++) p.push_back(8'h00);
    bits = 128'(l);
    bits = bits << 3;
    for (int j = 0; j < tsz; j++) p.push_back(bits[8*(tsz-1-j) +: 8]);
    nblk = p.size() / bsz;
    for (int b = 0; b < nblk; b++) begin
      logic [1023:0] v;
      v = '0;
      for (int i = 0; i < bsz; i++) v[1023-8*i -: 8] = p[b*bsz+i];
      exp_blk_q.push_back(v);
      exp_last_q.push_back(b == nblk - 1);
      exp_tag_q.push_back(tag);
    end
  endfunction

  // monitor: hold, stall and block contents on every falling edge
  bit prev_hold = 0;
  logic [1023:0] prev_blk;
  always @(negedge clk) begin
    if (rst_n) begin
      bit r;
      r = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      out_ready = r;
      if (prev_hold)
        chk(out_valid && out_block == prev_blk, "R8 hold", out_block, prev_blk);
      chk(!(in_ready && out_valid), "R8 stall", {1022'b0, in_ready, out_valid}, '0);
      if (out_valid && r) begin
        if (exp_blk_q.size() == 0) begin
          chk(1'b0, "R3 unexpected block", out_block, '0);
        end else begin
          logic [1023:0] e;
          bit el;
          string t;
          e = exp_blk_q.pop_front();
          el = exp_last_q.pop_front();
          t = exp_tag_q.pop_front();
          chk(out_block == e, t, out_block, e);
          chk(out_last == el, {t, " R5 last"}, {1023'b0, out_last}, {1023'b0, el});
        end
      end
      prev_hold = out_valid && !r;
      prev_blk = out_block;
    end
  end

  task automatic drive_beat(input logic [7:0] d, input bit keep, input bit last,
                            input bit mode);
    in_valid = 1'b1;
    in_data = d;
    in_keep = keep;
    in_last = last;
    mode_wide = mode;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_keep = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic send_msg(input int len, input bit wide, input bit flip,
                          input bit tail_empty, input int seed, input string tag);
    logic [7:0] m[$];
    for (int i = 0; i < len; i++) m.push_back(8'(seed * 7 + i * 13 + 1));
    build(m, wide, tag);
    if (len == 0) drive_beat(8'h00, 1'b0, 1'b1, wide);
    for (int i = 0; i < len; i++)
      drive_beat(m[i], 1'b1, (i == len - 1) && !tail_empty, (i == 0) ? wide : (wide ^ flip));
    if (tail_empty && len > 0) drive_beat(8'h00, 1'b0, 1'b1, wide ^ flip);
  endtask

  task automatic drain();
    while (exp_blk_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", {1023'b0, out_valid}, '0);
    chk(in_ready == 1'b1, "R1 in_ready", {1023'b0, in_ready}, {1023'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);

    // R11 latency and R2 narrow layout
    bp_mode = 0;
    send_msg(3, 1'b0, 1'b0, 1'b0, 1, "R2 R4 R5 narrow short");
    chk(out_valid == 1'b0, "R11 marker cycle", {1023'b0, out_valid}, '0);
    @(negedge clk);
    chk(out_valid && out_last, "R11 final due", {1022'b0, out_valid, out_last}, 1024'd3);
    chk(out_block[511:0] == '0, "R2 narrow low half", out_block, '0);
    drain();

    // R3 full block due next cycle
    send_msg(64, 1'b0, 1'b0, 1'b0, 2, "R3 R10 narrow full");
    chk(out_valid && !out_last, "R3 full block due", {1022'b0, out_valid, out_last}, 1024'd2);
    drain();

    send_msg(55, 1'b0, 1'b0, 1'b0, 3, "R4 R5 narrow 55");
    send_msg(56, 1'b0, 1'b0, 1'b0, 4, "R6 narrow spill 56");
    send_msg(63, 1'b0, 1'b0, 1'b0, 5, "R6 narrow spill 63");
    send_msg(0, 1'b0, 1'b0, 1'b0, 6, "R7 narrow empty");
    send_msg(130, 1'b0, 1'b0, 1'b0, 7, "R3 R10 narrow 130");
    drain();

    bp_mode = 1;
    send_msg(111, 1'b1, 1'b0, 1'b0, 8, "R5 R8 wide 111");
    send_msg(112, 1'b1, 1'b0, 1'b0, 9, "R6 R8 wide spill 112");
    send_msg(127, 1'b1, 1'b0, 1'b0, 10, "R6 wide spill 127");
    send_msg(128, 1'b1, 1'b0, 1'b0, 11, "R3 wide full 128");
    send_msg(0, 1'b1, 1'b0, 1'b0, 12, "R7 wide empty");
    send_msg(200, 1'b1, 1'b0, 1'b0, 13, "R5 R10 wide 200");
    send_msg(20, 1'b0, 1'b1, 1'b0, 14, "R9 narrow flip");
    send_msg(70, 1'b1, 1'b1, 1'b0, 15, "R9 wide flip");
    send_msg(5, 1'b0, 1'b0, 1'b1, 16, "R7 empty tail beat");
    send_msg(64, 1'b0, 1'b0, 1'b1, 17, "R7 R3 empty tail after full");
    drain();

    chk(out_valid == 1'b0, "R10 idle after drain", {1023'b0, out_valid}, '0);
    chk(in_ready == 1'b1, "R10 ready after drain", {1023'b0, in_ready}, {1023'b0, 1'b1});
    done = 1;
    finish_up();
  end
endmodule